// File: doc/BRIEF.md
# Strided Vector Address Generator

This block walks through the memory addresses of a single vector load or store. A one-cycle start pulse captures a base address, an element count and a signed stride. The block then presents one element request per cycle to the memory side. Each request carries the element address, the element's position in the vector, and a flag that marks the final element. The address is also split into a bank number and an offset within that bank, for a memory interleaved across 16 banks.

The memory side pushes back through a ready/valid handshake. While ready is low, the request on the outputs is held unchanged. One cycle after the final element is accepted, the block raises a single-cycle done pulse and is free to take the next start. The element count is limited to the capacity of one vector register, which is 64 by default. Address arithmetic wraps at the width of the address.

Top module: `vag_top`

## Requirements
- R1: After reset, `reqValidO` and `doneO` are both 0.
- R2: When `startI` is seen while no sequence is active and the latched length L is greater than 0, element 0 is presented in the next cycle. It has address `baseI`, index 0 and `reqValidO` high.
- R3: Element i has address `(base + i*stride) mod 2^24`, where the stride is a 24-bit two's-complement value.
- R4: While `reqReadyI` is held high, a new element is presented in every cycle, and the index rises by one each time.
- R5: While `reqValidO` is high and `reqReadyI` is low, the valid, address, index, last, bank and offset outputs keep their values into the next cycle.
- R6: `reqLastO` is 1 only while element L-1 is presented.
- R7: `doneO` is 1 for exactly one cycle, in the cycle after element L-1 is accepted, and `reqValidO` is 0 in that cycle.
- R8: A start with length 0 produces no request, and `doneO` is 1 in the cycle after the start.
- R9: A start that arrives while `reqValidO` is high is ignored. The running sequence keeps its base, stride, length and position.
- R10: `reqBankO` equals address bits [3:0] and `reqOffsetO` equals address bits [23:4]. As a result, a stride that is a multiple of 16 keeps every element in the same bank.
- R11: A length above 64 is clamped to 64 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startI | input | 1 | Start pulse for a new sequence |
| baseI | input | 24 | Address of element 0 |
| lenI | input | 7 | Number of elements (values above 64 are clamped) |
| strideI | input | 24 | Signed element-to-element address step |
| reqValidO | output | 1 | An element request is presented |
| reqReadyI | input | 1 | Memory accepts the presented request |
| reqAddrO | output | 24 | Element address |
| reqIdxO | output | 6 | Element index |
| reqLastO | output | 1 | Presented element is the final one |
| reqBankO | output | 4 | Bank number |
| reqOffsetO | output | 20 | Word offset inside the bank |
| doneO | output | 1 | Single-cycle end-of-sequence pulse |

## Verification
The bench sweeps lengths 0 to 5 against positive, negative, zero and bank-aligned strides. This separates a correct multiply-accumulate stepping from an off-by-one in the last flag or in the count. Bases near the top of the address space force the wrap. The sweeps are repeated with a periodic ready-low pattern, so that holding the output under stall is distinguishable from advancing anyway. Separate runs inject a start in the middle of a sequence, and use the full and over-long lengths to expose clamp and counter-width errors.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobes_t;
endpackage

// File: rtl/vag_bank_map.sv
module vag_bank_map #(
  parameter int ADDR_W    = 24,
  parameter int NUM_BANKS = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic [ADDR_W-1:0]        addrI,
  output logic [BANK_W-1:0]        bankO,
  output logic [ADDR_W-BANK_W-1:0] offsetO
);
  generate
    if (NUM_BANKS == (1 << BANK_W)) begin : g_pow2
      assign bankO   = addrI[BANK_W-1:0];
      assign offsetO = addrI[ADDR_W-1:BANK_W];
    end else begin : g_mod
      assign bankO   = BANK_W'(addrI % ADDR_W'(NUM_BANKS));
      assign offsetO = (ADDR_W-BANK_W)'(addrI / ADDR_W'(NUM_BANKS));
    end
  endgenerate
endmodule

// File: rtl/vag_ctrl.sv
module vag_ctrl
  import vag_pkg::*;
#(
  parameter int MAX_LEN = 64,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startI,
  input  logic [LEN_W-1:0] lenI,
  input  logic             readyI,
  output logic             activeO,
  output logic [IDX_W-1:0] idxO,
  output logic             lastO,
  output logic             doneO,
  output ctrlStrobes_t     strobesO
);
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] lenClamped;
  logic             acceptStart;

  assign lenClamped  = (lenI > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : lenI;
  assign acceptStart = startI && !activeO;
  assign lastO       = activeO && ({1'b0, idxO} == LEN_W'(lenReg - LEN_W'(1)));

  always_comb begin
    strobesO.load = acceptStart;
    strobesO.step = activeO && readyI && !lastO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeO <= 1'b0;
      idxO    <= '0;
      lenReg  <= '0;
      doneO   <= 1'b0;
    end else begin
      doneO <= 1'b0;
      if (acceptStart) begin
        lenReg  <= lenClamped;
        idxO    <= '0;
        activeO <= (lenClamped != '0);
        doneO   <= (lenClamped == '0);
      end else if (activeO && readyI) begin
        if (lastO) begin
          activeO <= 1'b0;
          doneO   <= 1'b1;
        end else begin
          idxO <= idxO + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vag_dp.sv
module vag_dp
  import vag_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobesI,
  input  logic [ADDR_W-1:0] baseI,
  input  logic [ADDR_W-1:0] strideI,
  output logic [ADDR_W-1:0] addrO
);
  logic [ADDR_W-1:0] strideReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrO     <= '0;
      strideReg <= '0;
    end else if (strobesI.load) begin
      addrO     <= baseI;
      strideReg <= strideI;
    end else if (strobesI.step) begin
      addrO <= addrO + strideReg;
    end
  end
endmodule

// File: rtl/vag_top.sv
module vag_top
  import vag_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MAX_LEN   = 64,
  parameter int NUM_BANKS = 16,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int IDX_W    = $clog2(MAX_LEN),
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startI,
  input  logic [ADDR_W-1:0]        baseI,
  input  logic [LEN_W-1:0]         lenI,
  input  logic [ADDR_W-1:0]        strideI,
  output logic                     reqValidO,
  input  logic                     reqReadyI,
  output logic [ADDR_W-1:0]        reqAddrO,
  output logic [IDX_W-1:0]         reqIdxO,
  output logic                     reqLastO,
  output logic [BANK_W-1:0]        reqBankO,
  output logic [ADDR_W-BANK_W-1:0] reqOffsetO,
  output logic                     doneO
);
  ctrlStrobes_t strobes;

  vag_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .startI(startI), .lenI(lenI),
    .readyI(reqReadyI), .activeO(reqValidO), .idxO(reqIdxO),
    .lastO(reqLastO), .doneO(doneO), .strobesO(strobes)
  );

  vag_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobesI(strobes), .baseI(baseI),
    .strideI(strideI), .addrO(reqAddrO)
  );

  vag_bank_map #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_map (
    .addrI(reqAddrO), .bankO(reqBankO), .offsetO(reqOffsetO)
  );
endmodule

// File: rtl/vag_checker.sv
module vag_checker #(
  parameter int ADDR_W    = 24,
  parameter int MAX_LEN   = 64,
  parameter int NUM_BANKS = 16,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int IDX_W    = $clog2(MAX_LEN),
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     startI,
  input logic [LEN_W-1:0]         lenI,
  input logic                     reqValidO,
  input logic                     reqReadyI,
  input logic [ADDR_W-1:0]        reqAddrO,
  input logic [IDX_W-1:0]         reqIdxO,
  input logic                     reqLastO,
  input logic [BANK_W-1:0]        reqBankO,
  input logic [ADDR_W-BANK_W-1:0] reqOffsetO,
  input logic                     doneO
);
  p_first_idx_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValidO) |-> reqIdxO == '0);

  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValidO && reqReadyI && !reqLastO |=> reqValidO && reqIdxO == $past(reqIdxO) + IDX_W'(1));

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValidO && !reqReadyI |=> reqValidO && $stable(reqAddrO) && $stable(reqIdxO) && $stable(reqLastO));

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValidO && reqReadyI && reqLastO |=> doneO && !reqValidO);

  p_done_no_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> !reqValidO);

  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    startI && !reqValidO && lenI == '0 |=> doneO && !reqValidO);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    startI && reqValidO && !reqReadyI |=> $stable(reqAddrO) && $stable(reqIdxO));

  always_comb begin
    if (rstN) begin
      p_bank_split_r10: assert ({reqOffsetO, reqBankO} == reqAddrO);
    end
  end
endmodule

bind vag_top vag_checker #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN), .NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/vag_top_bench.sv
module vag_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startI = 1'b0;
  logic [23:0] baseI = '0;
  logic [6:0]  lenI = '0;
  logic [23:0] strideI = '0;
  logic        reqReadyI = 1'b0;
  logic        reqValidO, reqLastO, doneO;
  logic [23:0] reqAddrO;
  logic [5:0]  reqIdxO;
  logic [3:0]  reqBankO;
  logic [19:0] reqOffsetO;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vag_top u_vag_top (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one sequence; stall pulls ready low every third cycle,
  // injectAt pulses a conflicting start at that cycle (-1: none).
  task automatic runSeq(input logic [23:0] base, input int len, input int stride,
                        input bit stall, input int injectAt);
    int expLen = (len > 64) ? 64 : len;
    int e = 0;
    int cyc = 0;
    logic [23:0] expAddr;
    @(negedge clk);
    startI = 1'b1; baseI = base; lenI = 7'(len); strideI = 24'(stride);
    reqReadyI = 1'b0;
    @(negedge clk);
    startI = 1'b0;
    if (expLen == 0) begin
      chk("R8 done", 32'(doneO), 1);
      chk("R8 no request", 32'(reqValidO), 0);
    end else begin
      while (e < expLen) begin
        reqReadyI = stall ? (cyc % 3 != 1) : 1'b1;
        if (cyc == injectAt) begin
          startI = 1'b1; baseI = ~base; lenI = 7'd3; strideI = 24'd5;
        end else begin
          startI = 1'b0;
        end
        expAddr = 24'(int'(base) + e * stride);
        chk("R2/R4 valid", 32'(reqValidO), 1);
        chk("R3 address", 32'(reqAddrO), 32'(expAddr));
        chk("R4 index", 32'(reqIdxO), 32'(e));
        chk("R6 last", 32'(reqLastO), 32'(e == expLen - 1));
        chk("R10 bank", 32'(reqBankO), 32'(expAddr[3:0]));
        chk("R10 offset", 32'(reqOffsetO), 32'(expAddr[23:4]));
        if (e > 0 || cyc > 0) chk("R7 no early done", 32'(doneO), 0);
        if (reqReadyI) e++;
        cyc++;
        @(negedge clk);
      end
      startI = 1'b0;
      reqReadyI = 1'b0;
      chk("R7 done", 32'(doneO), 1);
      chk("R7 valid low", 32'(reqValidO), 0);
    end
    @(negedge clk);
    chk("R7 done single", 32'(doneO), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int strides[10] = '{0, 1, -1, 2, -3, 7, 16, -16, 64, 1000};
    logic [23:0] bases[3] = '{24'h000100, 24'hFFFFF8, 24'h000003};
    #1;
    chk("R1 valid reset", 32'(reqValidO), 0);
    chk("R1 done reset", 32'(doneO), 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid idle", 32'(reqValidO), 0);
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 10; s++)
        for (int l = 0; l <= 5; l++)
          for (int st = 0; st < 2; st++)
            runSeq(bases[b], l, strides[s], st[0], -1);
    runSeq(24'h000040, 6, 16, 1'b0, -1);   // R10 same bank
    runSeq(24'h000200, 6, 3, 1'b0, 2);     // R9 start mid-sequence
    runSeq(24'h000200, 6, -5, 1'b1, 1);    // R9 under stall
    runSeq(24'h123456, 64, 4, 1'b0, -1);   // full length
    runSeq(24'h000010, 70, -8, 1'b1, -1);  // R11 clamp
    runSeq(24'h000010, 127, 1, 1'b0, -1);  // R11 clamp
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule